// File: doc/BRIEF.md
# Spin-lock acquisition controller with exponential retry delay

This controller wins a shared lock word for one client. The client raises an acquire request. The controller then reads the lock word with plain reads and keeps reading while the word is non-zero. As soon as a read returns zero, it issues one atomic test-and-set. If the test-and-set returns zero, the lock is owned and the client sees grant. If it returns non-zero, another agent got there first. The controller then stays silent on the memory port for a delay and starts reading again.

The delay after a failed attempt grows geometrically. The n-th failure since the current acquire (counting from zero) waits BASE_WAIT·GROWTH^n cycles. The exponent stops growing at MAX_RETRY. When the client drops the lock, the controller writes zero to the lock word and returns to idle.

The memory port uses a request/acknowledge handshake. The controller holds mem_req and mem_op steady until mem_ack. Read data is taken in the cycle mem_ack is high.

Top module: `spin_lock_agent`

## Requirements
- R1: After an acquire request, the controller issues reads (mem_op 2'b00) and repeats them while the returned word is non-zero. It issues a test-and-set (mem_op 2'b01) only directly after a read that returned zero.
- R2: When a test-and-set returns non-zero, mem_req stays low for exactly BASE_WAIT·GROWTH^n cycles, where n is the number of earlier failures in this acquire. A read request follows.
- R3: When a test-and-set returns zero, grant rises in the next cycle. Grant stays high with no memory request until a release request is seen.
- R4: A release request while grant is high drops grant in the next cycle. It also raises one write-zero request (mem_op 2'b10). After that request is acknowledged the controller is idle, with no request and no grant.
- R5: Once mem_req is raised, it and mem_op stay unchanged until the cycle in which mem_ack is high.
- R6: The exponent n stops at MAX_RETRY, so all failures from number MAX_RETRY on wait BASE_WAIT·GROWTH^MAX_RETRY cycles.
- R7: Each new acquire starts the exponent again from zero.
- R8: A release request while grant is low has no effect. In idle, no request is made. During an acquisition, no write-zero is issued and the acquisition goes on.
- R9: In reset and directly after it, mem_req and grant are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | 1 | Client asks for the lock (sampled in idle) |
| rel_req | input | 1 | Client gives the lock back (acted on only while granted) |
| grant | output | 1 | Lock is owned on behalf of the client |
| mem_req | output | 1 | Memory request valid |
| mem_op | output | 2 | 00 read, 01 test-and-set, 10 write zero |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | DATA_W | Lock word returned with mem_ack |

## Verification
The bench scripts how many reads find the lock busy and how many test-and-sets fail. It then measures each silent gap on the memory port. A delay counter that is off by one shows up as a gap one cycle long or short. A missing cap on the exponent shows up as gaps that keep doubling past the cap. An exponent that survives from the previous acquire shows up as a first gap that does not equal BASE_WAIT.

The bench also tracks whether each test-and-set was preceded by a zero read. A controller that goes straight to the atomic operation fails this check. So does one that treats a busy read as free.

Release pulses are sent while idle and while busy-polling. A controller that acted on them would issue a stray write-zero or abandon the acquisition.

// File: rtl/spin_lock_agent.sv
module spin_lock_agent #(
  parameter int DATA_W    = 8,
  parameter int BASE_WAIT = 3,
  parameter int GROWTH    = 2,
  parameter int MAX_RETRY = 3,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              grant,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [IDX_W-1:0] IDX_CAP = IDX_W'(MAX_RETRY);
  localparam logic [1:0] OP_READ = 2'b00, OP_TAS = 2'b01, OP_CLEAR = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_TAS, S_BACKOFF, S_HELD, S_RELEASE} state_t;

  state_t           state;
  logic [IDX_W-1:0] retry;
  logic [CNT_W-1:0] wait_cnt;
  logic             word_free;

  assign word_free = (mem_rdata == '0);

  function automatic logic [CNT_W-1:0] wait_len(input logic [IDX_W-1:0] idx);
    logic [CNT_W-1:0] v;
    v = CNT_W'(BASE_WAIT);
    for (int j = 0; j < MAX_RETRY; j++)
      if (j < int'(idx)) v = v * CNT_W'(GROWTH);
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      retry    <= '0;
      wait_cnt <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (acq_req) begin
            state <= S_POLL;
            retry <= '0;
          end
        S_POLL:
          if (mem_ack && word_free) state <= S_TAS;
        S_TAS:
          if (mem_ack) begin
            if (word_free) state <= S_HELD;
            else begin
              state    <= S_BACKOFF;
              wait_cnt <= wait_len(retry) - 1'b1;
              if (retry != IDX_CAP) retry <= retry + 1'b1;
            end
          end
        S_BACKOFF:
          if (wait_cnt == '0) state <= S_POLL;
          else wait_cnt <= wait_cnt - 1'b1;
        S_HELD:
          if (rel_req) state <= S_RELEASE;
        S_RELEASE:
          if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign grant   = (state == S_HELD);
  assign mem_req = (state == S_POLL) || (state == S_TAS) || (state == S_RELEASE);
  assign mem_op  = (state == S_TAS) ? OP_TAS : (state == S_RELEASE) ? OP_CLEAR : OP_READ;

  AST_TAS_AFTER_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_op == OP_TAS && !$past(mem_req && mem_op == OP_TAS))
      |-> $past(mem_ack && mem_op == OP_READ && mem_rdata == '0)); // R1
  AST_QUIET_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_op == OP_TAS && mem_rdata != '0) |=> !mem_req); // R2
  AST_GRANT_FROM_TAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(mem_ack && mem_op == OP_TAS && mem_rdata == '0)); // R3
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant) |-> (mem_req && mem_op == OP_CLEAR)); // R4
  AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op))); // R5
  AST_RETRY_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= IDX_CAP); // R6
  AST_IDLE_REL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rel_req && !acq_req) |=> (!mem_req && !grant)); // R8

endmodule

// File: tb/spin_lock_agent_bench.sv
`timescale 1ns/1ps
module spin_lock_agent_bench;
  localparam int K = 3, C = 2, CAP = 3;

  logic clk = 1'b0, rst_n = 1'b0, acq_req = 1'b0, rel_req = 1'b0;
  logic grant, mem_req, mem_ack;
  logic [1:0] mem_op;
  logic [7:0] mem_rdata;

  int checks = 0, fails = 0;
  int scr_busy = 0, scr_fail = 0;
  int rd_cnt = 0, tas_cnt = 0, clr_cnt = 0;
  int gaps [0:15];
  int gap_n = 0, gap = 0, hold_bad = 0, order_bad = 0;
  bit meas = 0, prev_pend = 0, prev_req = 0, last_zero = 0;
  logic [1:0] prev_op = 2'b00;

  always #2 clk = ~clk;

  spin_lock_agent #(.DATA_W(8), .BASE_WAIT(K), .GROWTH(C), .MAX_RETRY(CAP), .CNT_W(16)) u_spin_lock_agent (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req), .grant(grant),
    .mem_req(mem_req), .mem_op(mem_op), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= 8'h00; rd_cnt <= 0; tas_cnt <= 0; clr_cnt <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        case (mem_op)
          2'b00: begin mem_rdata <= (rd_cnt < scr_busy) ? 8'h01 : 8'h00; rd_cnt <= rd_cnt + 1; end
          2'b01: begin mem_rdata <= (tas_cnt < scr_fail) ? 8'h01 : 8'h00; tas_cnt <= tas_cnt + 1; end
          default: begin mem_rdata <= 8'h00; rd_cnt <= 0; tas_cnt <= 0; clr_cnt <= clr_cnt + 1; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && (!mem_req || mem_op != prev_op)) hold_bad++;
      if (mem_req && mem_op == 2'b01 && !(prev_req && prev_op == 2'b01) && !last_zero) order_bad++;
      if (mem_req && mem_ack && mem_op == 2'b00) last_zero = (mem_rdata == 8'h00);
      if (mem_req && mem_ack && mem_op == 2'b01) last_zero = 0;
      if (mem_req && mem_ack && mem_op == 2'b01 && mem_rdata != 8'h00) begin
        meas = 1; gap = 0;
      end else if (meas) begin
        if (!mem_req) gap++;
        else begin
          if (gap_n < 16) gaps[gap_n] = gap;
          gap_n++; meas = 0;
        end
      end
      if (mem_req && mem_ack && mem_op == 2'b10) gap_n = 0;
      prev_pend = mem_req && !mem_ack;
      prev_req = mem_req;
      prev_op = mem_op;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input int n);
    int v = K;
    for (int j = 0; j < ((n < CAP) ? n : CAP); j++) v = v * C;
    return v;
  endfunction

  task automatic run_acq(input int busy, input int nfail, input bit rel_mid);
    int waited = 0;
    int clr0;
    @(negedge clk);
    scr_busy = busy; scr_fail = nfail; acq_req = 1'b1;
    clr0 = clr_cnt;
    while (!grant && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (rel_mid && waited == 4) rel_req = 1'b1;
      if (rel_mid && waited == 5) rel_req = 1'b0;
    end
    acq_req = 1'b0;
    chk(grant, "R3 grant after free test-and-set", int'(grant), 1);
    chk(rd_cnt == busy + 1 + nfail, "R1 read count", rd_cnt, busy + 1 + nfail);
    chk(tas_cnt == nfail + 1, "R1 test-and-set count", tas_cnt, nfail + 1);
    chk(gap_n == nfail, "R2 number of retry gaps", gap_n, nfail);
    for (int j = 0; j < nfail && j < 16; j++)
      chk(gaps[j] == exp_wait(j), (j >= CAP) ? "R6 capped retry gap" : "R2 R7 retry gap", gaps[j], exp_wait(j));
    if (rel_mid) chk(clr_cnt == clr0, "R8 no write-zero during acquisition", clr_cnt, clr0);
    repeat (3) begin
      @(negedge clk);
      chk(grant && !mem_req, "R3 grant held quietly", int'({grant, mem_req}), 2);
    end
    rel_req = 1'b1;
    @(negedge clk);
    rel_req = 1'b0;
    chk(!grant && mem_req && mem_op == 2'b10, "R4 write-zero on release",
        int'({grant, mem_req, mem_op}), 6);
    @(negedge clk);
    @(negedge clk);
    chk(!grant && !mem_req && clr_cnt == clr0 + 1, "R4 idle after release",
        int'({grant, mem_req}) * 100 + clr_cnt, clr0 + 1);
  endtask

  localparam int VEC [5][2] = '{'{0, 0}, '{2, 0}, '{0, 1}, '{3, 2}, '{1, 5}};

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && !grant, "R9 quiet in reset", int'({mem_req, grant}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !grant, "R9 quiet after reset", int'({mem_req, grant}), 0);

    for (int v = 0; v < 5; v++) run_acq(VEC[v][0], VEC[v][1], 1'b0);

    rel_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req && !grant, "R8 release ignored in idle", int'({mem_req, grant}), 0);
    end
    rel_req = 1'b0;

    run_acq(6, 1, 1'b1);
    run_acq(0, 2, 1'b0);

    chk(hold_bad == 0, "R5 request steady until ack", hold_bad, 0);
    chk(order_bad == 0, "R1 test-and-set only after zero read", order_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual 100000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule